// File: doc/BRIEF.md
# Exception Entry Prioritiser

This block sits beside a small 32-bit processor core and decides which pending exception the core enters next. Seven sources compete: a reset request, a data abort, a prefetch abort, a software interrupt and an undefined-instruction trap, all synchronous to the core clock, plus fast and normal interrupt lines that arrive asynchronously. The block picks one winner by a fixed priority and issues a one-cycle entry pulse. With the pulse it gives the entry vector address, a 3-bit code for the processor mode to enter, the updated interrupt mask bits, and a flag that tells the core to resume in the 32-bit instruction state.

The two interrupt lines first pass through a flip-flop synchroniser. After that they are latched as pending only in a cycle where the core signals an instruction boundary. Synchronous sources skip that gating and go straight to arbitration. A registered selection stage then feeds a registered output stage. From an interrupt request to its entry pulse this gives a fixed minimum of five cycles, and two cycles for a synchronous source. Fast interrupts keep working while a normal-interrupt handler runs, because a normal-interrupt entry masks only normal interrupts.

Top module: `exc_entry_unit`

## Requirements
- R1: Priority, from highest to lowest: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, then software interrupt and undefined instruction. The last two are never high together.
- R2: The vector address, zero-extended to ADDR_W bits, is 0x00 for reset, 0x04 for undefined instruction, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R3: The mode code is 1 (supervisor) for reset and software interrupt, 2 (abort) for both aborts, 3 for undefined instruction, 4 for normal interrupt and 5 for fast interrupt.
- R4: `takeExc` is high for exactly one cycle per entry, and at least one low cycle separates two entries. `vecAddr` and `modeCode` change only on the edge that raises `takeExc`, and they keep their values until the next entry.
- R5: An interrupt request that is high for one cycle before edge 1, with the boundary strobe and the unmask held, raises `takeExc` after edge SYNC_STAGES+3. With the default that is edge 5, and `takeExc` is low after edge 4.
- R6: An interrupt request is latched as pending only in a cycle where `instrBoundary` is high at the synchroniser output. A request that has gone before any such cycle is dropped and never taken.
- R7: A synchronous source that is high in the cycle before edge N gives `takeExc` after edge N+1, whatever the state of `instrBoundary`. A synchronous source that loses arbitration is dropped, while a pending interrupt that loses stays pending and is taken later.
- R8: During `takeExc`, `maskIrqOut` is 1. `maskFiqOut` is 1 for reset and fast-interrupt entries and equals `maskFiqIn` otherwise. Outside `takeExc`, both outputs equal their inputs.
- R9: A masked interrupt is not taken, and if its mask is set while it is pending it is discarded. A fast interrupt is taken while `maskIrqIn` is high.
- R10: `wordState`, the flag for resuming in the 32-bit instruction state, is high exactly in the cycles where `takeExc` is high.
- R11: While `rstN` is low, and after it is released with no request present, `takeExc` is 0, `vecAddr` is 0 and `modeCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset of the block's flops |
| resetReq | input | 1 | Reset exception request |
| dataAbort | input | 1 | Data abort request |
| prefAbort | input | 1 | Prefetch abort request |
| swInt | input | 1 | Software interrupt request |
| undefInstr | input | 1 | Undefined instruction request |
| fiqReq | input | 1 | Asynchronous fast interrupt request |
| irqReq | input | 1 | Asynchronous normal interrupt request |
| instrBoundary | input | 1 | High when the core is at an instruction boundary |
| maskFiqIn | input | 1 | Current fast-interrupt mask |
| maskIrqIn | input | 1 | Current normal-interrupt mask |
| takeExc | output | 1 | One-cycle exception entry pulse |
| vecAddr | output | ADDR_W | Entry vector address |
| modeCode | output | 3 | Mode to enter |
| maskFiqOut | output | 1 | Updated fast-interrupt mask |
| maskIrqOut | output | 1 | Updated normal-interrupt mask |
| wordState | output | 1 | Resume in the 32-bit instruction state |

## Verification
The bench builds the block with ADDR_W of 32 and SYNC_STAGES of 2. This makes the five-cycle interrupt latency a fixed cycle count that the bench can check at the exact edge. With that count known, the bench can time a data abort to land in the same selection cycle as a pending fast interrupt. Two-stage synchronisation with the boundary strobe held high also lets single-cycle interrupt pulses reach the pending latch, so that gating by the strobe and by the masks can each be shown to drop a request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // Source indices; the order of the if-chain in the arbiter sets priority.
  typedef enum logic [2:0] {
    SRC_RESET = 3'd0,
    SRC_DABT  = 3'd1,
    SRC_FIQ   = 3'd2,
    SRC_IRQ   = 3'd3,
    SRC_PABT  = 3'd4,
    SRC_SWI   = 3'd5,
    SRC_UND   = 3'd6
  } excSrc_e;

  localparam logic [2:0] MODE_SUP = 3'd1;
  localparam logic [2:0] MODE_ABT = 3'd2;
  localparam logic [2:0] MODE_UND = 3'd3;
  localparam logic [2:0] MODE_IRQ = 3'd4;
  localparam logic [2:0] MODE_FIQ = 3'd5;

  localparam int VEC_OFF_W = 8;

  // Control-to-datapath strobe bundle.
  typedef struct packed {
    logic    load;
    excSrc_e src;
  } ctrlStrobe_t;

  function automatic logic [VEC_OFF_W-1:0] vecOffset(input excSrc_e s);
    case (s)
      SRC_RESET: vecOffset = 8'h00;
      SRC_UND:   vecOffset = 8'h04;
      SRC_SWI:   vecOffset = 8'h08;
      SRC_PABT:  vecOffset = 8'h0C;
      SRC_DABT:  vecOffset = 8'h10;
      SRC_IRQ:   vecOffset = 8'h18;
      SRC_FIQ:   vecOffset = 8'h1C;
      default:   vecOffset = 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] modeOf(input excSrc_e s);
    case (s)
      SRC_RESET, SRC_SWI: modeOf = MODE_SUP;
      SRC_DABT, SRC_PABT: modeOf = MODE_ABT;
      SRC_UND:            modeOf = MODE_UND;
      SRC_IRQ:            modeOf = MODE_IRQ;
      SRC_FIQ:            modeOf = MODE_FIQ;
      default:            modeOf = MODE_SUP;
    endcase
  endfunction

  function automatic logic setsFiqMask(input excSrc_e s);
    setsFiqMask = (s == SRC_RESET) || (s == SRC_FIQ);
  endfunction

endpackage

// File: rtl/exc_req_sync.sv
module exc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= asyncIn;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn};
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/exc_arb_ctrl.sv
module exc_arb_ctrl
  import exc_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        resetReq,
  input  logic        dataAbort,
  input  logic        prefAbort,
  input  logic        swInt,
  input  logic        undefInstr,
  input  logic        fiqSync,
  input  logic        irqSync,
  input  logic        instrBoundary,
  input  logic        maskFiqIn,
  input  logic        maskIrqIn,
  output ctrlStrobe_t strobe
);

  logic    pendFiq, pendIrq;
  logic    fiqLive, irqLive;
  logic    anyReq, grant;
  excSrc_e winner;

  assign fiqLive = pendFiq && !maskFiqIn;
  assign irqLive = pendIrq && !maskIrqIn;

  always_comb begin
    anyReq = 1'b1;
    winner = SRC_RESET;
    if (resetReq)        winner = SRC_RESET;
    else if (dataAbort)  winner = SRC_DABT;
    else if (fiqLive)    winner = SRC_FIQ;
    else if (irqLive)    winner = SRC_IRQ;
    else if (prefAbort)  winner = SRC_PABT;
    else if (swInt)      winner = SRC_SWI;
    else if (undefInstr) winner = SRC_UND;
    else                 anyReq = 1'b0;
  end

  // One selection per two cycles keeps the entry pulse isolated.
  assign grant = anyReq && !strobe.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe  <= '{load: 1'b0, src: SRC_RESET};
      pendFiq <= 1'b0;
      pendIrq <= 1'b0;
    end else begin
      strobe.load <= grant;
      if (grant) strobe.src <= winner;
      pendFiq <= (fiqLive && !(grant && winner == SRC_FIQ))
               || (instrBoundary && fiqSync && !maskFiqIn);
      pendIrq <= (irqLive && !(grant && winner == SRC_IRQ))
               || (instrBoundary && irqSync && !maskIrqIn);
    end
  end

  // R6
  boundary_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendFiq) |-> $past(instrBoundary));

  // R4
  select_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !strobe.load);

  // R1
  reset_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && !strobe.load) |=> (strobe.load && strobe.src == SRC_RESET));

  // R9
  fiq_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.src == SRC_FIQ) |-> !$past(maskFiqIn));

endmodule

// File: rtl/exc_vec_dpath.sv
module exc_vec_dpath
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              maskFiqIn,
  input  logic              maskIrqIn,
  output logic              takeExc,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [2:0]        modeCode,
  output logic              maskFiqOut,
  output logic              maskIrqOut,
  output logic              wordState
);

  localparam int PAD_W = ADDR_W - VEC_OFF_W;

  logic takeReg, fiqSetReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeReg   <= 1'b0;
      fiqSetReg <= 1'b0;
      vecAddr   <= '0;
      modeCode  <= '0;
    end else begin
      takeReg <= strobe.load;
      if (strobe.load) begin
        vecAddr   <= {{PAD_W{1'b0}}, vecOffset(strobe.src)};
        modeCode  <= modeOf(strobe.src);
        fiqSetReg <= setsFiqMask(strobe.src);
      end
    end
  end

  assign takeExc    = takeReg;
  assign wordState  = takeReg;
  assign maskIrqOut = takeReg ? 1'b1 : maskIrqIn;
  assign maskFiqOut = (takeReg && fiqSetReg) ? 1'b1 : maskFiqIn;

  // R4
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> !takeExc);

  // R2
  fiq_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && modeCode == MODE_FIQ) |-> vecAddr == ADDR_W'('h1C));

  // R8
  fiq_mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && modeCode == MODE_FIQ) |-> (maskFiqOut && maskIrqOut));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              dataAbort,
  input  logic              prefAbort,
  input  logic              swInt,
  input  logic              undefInstr,
  input  logic              fiqReq,
  input  logic              irqReq,
  input  logic              instrBoundary,
  input  logic              maskFiqIn,
  input  logic              maskIrqIn,
  output logic              takeExc,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [2:0]        modeCode,
  output logic              maskFiqOut,
  output logic              maskIrqOut,
  output logic              wordState
);

  logic        fiqSync, irqSync;
  ctrlStrobe_t strobe;

  exc_req_sync #(.STAGES(SYNC_STAGES)) u_fiqSync (
    .clk(clk), .rstN(rstN), .asyncIn(fiqReq), .syncOut(fiqSync));

  exc_req_sync #(.STAGES(SYNC_STAGES)) u_irqSync (
    .clk(clk), .rstN(rstN), .asyncIn(irqReq), .syncOut(irqSync));

  exc_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .resetReq(resetReq), .dataAbort(dataAbort), .prefAbort(prefAbort),
    .swInt(swInt), .undefInstr(undefInstr),
    .fiqSync(fiqSync), .irqSync(irqSync),
    .instrBoundary(instrBoundary),
    .maskFiqIn(maskFiqIn), .maskIrqIn(maskIrqIn),
    .strobe(strobe));

  exc_vec_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .maskFiqIn(maskFiqIn), .maskIrqIn(maskIrqIn),
    .takeExc(takeExc), .vecAddr(vecAddr), .modeCode(modeCode),
    .maskFiqOut(maskFiqOut), .maskIrqOut(maskIrqOut), .wordState(wordState));

endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;

  localparam int ADDR_W = 32;
  localparam int NVEC   = 9;

  logic clk = 1'b0;
  logic rstN, resetReq, dataAbort, prefAbort, swInt, undefInstr;
  logic fiqReq, irqReq, instrBoundary, maskFiqIn, maskIrqIn;
  logic takeExc, maskFiqOut, maskIrqOut, wordState;
  logic [ADDR_W-1:0] vecAddr;
  logic [2:0] modeCode;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  exc_entry_unit #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_exc_entry_unit (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .dataAbort(dataAbort),
    .prefAbort(prefAbort), .swInt(swInt), .undefInstr(undefInstr),
    .fiqReq(fiqReq), .irqReq(irqReq), .instrBoundary(instrBoundary),
    .maskFiqIn(maskFiqIn), .maskIrqIn(maskIrqIn), .takeExc(takeExc),
    .vecAddr(vecAddr), .modeCode(modeCode), .maskFiqOut(maskFiqOut),
    .maskIrqOut(maskIrqOut), .wordState(wordState));

  // Fields: [16:12] {reset, dabt, pabt, swi, und}, [11:4] vector, [3:1] mode, [0] fiq mask set
  localparam logic [16:0] TBL [NVEC] = '{
    {5'b10000, 8'h00, 3'd1, 1'b1},
    {5'b01000, 8'h10, 3'd2, 1'b0},
    {5'b00100, 8'h0C, 3'd2, 1'b0},
    {5'b00010, 8'h08, 3'd1, 1'b0},
    {5'b00001, 8'h04, 3'd3, 1'b0},
    {5'b01100, 8'h10, 3'd2, 1'b0},
    {5'b00110, 8'h0C, 3'd2, 1'b0},
    {5'b11001, 8'h00, 3'd1, 1'b1},
    {5'b01010, 8'h10, 3'd2, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic checkEntry(input string req, input logic [7:0] vec, input logic [2:0] mode,
                            input logic fiqM, input logic irqM);
    chk({req, " take"}, 32'(takeExc), 32'd1);
    chk({req, " vector"}, vecAddr, {24'd0, vec});
    chk({req, " mode"}, 32'(modeCode), 32'(mode));
    chk({req, " fiq mask"}, 32'(maskFiqOut), 32'(fiqM));
    chk({req, " irq mask"}, 32'(maskIrqOut), 32'(irqM));
    chk({req, " R10 wordState"}, 32'(wordState), 32'd1);
  endtask

  task automatic countTakes(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (takeExc) cnt++;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int cnt;
    rstN = 1'b0; resetReq = 0; dataAbort = 0; prefAbort = 0; swInt = 0; undefInstr = 0;
    fiqReq = 0; irqReq = 0; instrBoundary = 1; maskFiqIn = 0; maskIrqIn = 0;
    waitNeg(3);
    // R11 reset state
    chk("R11 take in reset", 32'(takeExc), 32'd0);
    chk("R11 vector in reset", vecAddr, 32'd0);
    chk("R11 mode in reset", 32'(modeCode), 32'd0);
    rstN = 1'b1;
    waitNeg(2);
    chk("R11 take after release", 32'(takeExc), 32'd0);
    chk("R10 wordState idle", 32'(wordState), 32'd0);
    chk("R8 mask passthrough idle", 32'(maskIrqOut), 32'd0);

    // R1 R2 R3 R7 R8 table of synchronous sources
    for (int i = 0; i < NVEC; i++) begin
      {resetReq, dataAbort, prefAbort, swInt, undefInstr} = TBL[i][16:12];
      @(negedge clk);
      {resetReq, dataAbort, prefAbort, swInt, undefInstr} = 5'b0;
      chk("R7 not yet taken", 32'(takeExc), 32'd0);
      @(negedge clk);
      checkEntry("R1/R2/R3 table", TBL[i][11:4], TBL[i][3:1], TBL[i][0], 1'b1);
      @(negedge clk);
      chk("R4 pulse ends", 32'(takeExc), 32'd0);
      chk("R4 vector holds", vecAddr, {24'd0, TBL[i][11:4]});
      waitNeg(2);
    end

    // R5 fast interrupt latency
    fiqReq = 1; @(negedge clk); fiqReq = 0;
    waitNeg(3);
    chk("R5 not taken after edge 4", 32'(takeExc), 32'd0);
    @(negedge clk);
    checkEntry("R5 fiq entry", 8'h1C, 3'd5, 1'b1, 1'b1);
    waitNeg(4);

    // R1 R4 fast and normal interrupt together
    fiqReq = 1; irqReq = 1; @(negedge clk); fiqReq = 0; irqReq = 0;
    waitNeg(4);
    checkEntry("R1 fiq before irq", 8'h1C, 3'd5, 1'b1, 1'b1);
    @(negedge clk);
    chk("R4 gap between entries", 32'(takeExc), 32'd0);
    @(negedge clk);
    checkEntry("R1 irq after fiq", 8'h18, 3'd4, 1'b0, 1'b1);
    waitNeg(4);

    // R7 data abort beats a pending fast interrupt, which stays pending
    fiqReq = 1; @(negedge clk); fiqReq = 0;
    waitNeg(2);
    dataAbort = 1; @(negedge clk); dataAbort = 0;
    @(negedge clk);
    checkEntry("R7 dabt over fiq", 8'h10, 3'd2, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 gap", 32'(takeExc), 32'd0);
    @(negedge clk);
    checkEntry("R7 fiq retained", 8'h1C, 3'd5, 1'b1, 1'b1);
    waitNeg(4);

    // R9 masked normal interrupt ignored, fast one accepted under irq mask
    maskIrqIn = 1;
    irqReq = 1; @(negedge clk); irqReq = 0;
    countTakes(8, cnt);
    chk("R9 masked irq ignored", 32'(cnt), 32'd0);
    fiqReq = 1; @(negedge clk); fiqReq = 0;
    waitNeg(4);
    checkEntry("R9 fiq under irq mask", 8'h1C, 3'd5, 1'b1, 1'b1);
    waitNeg(2);
    maskIrqIn = 0;
    countTakes(8, cnt);
    chk("R9 masked irq not replayed", 32'(cnt), 32'd0);

    // R9 mask raised while pending discards it
    irqReq = 1; @(negedge clk); irqReq = 0;
    waitNeg(2);
    maskIrqIn = 1;
    countTakes(4, cnt);
    maskIrqIn = 0;
    countTakes(6, cnt);
    chk("R9 pending irq discarded", 32'(cnt), 32'd0);

    // R6 boundary low: request dropped; R7 abort still taken
    instrBoundary = 0;
    irqReq = 1; @(negedge clk); irqReq = 0;
    countTakes(6, cnt);
    chk("R6 no capture without boundary", 32'(cnt), 32'd0);
    instrBoundary = 1;
    countTakes(6, cnt);
    chk("R6 dropped request", 32'(cnt), 32'd0);
    instrBoundary = 0;
    prefAbort = 1; @(negedge clk); prefAbort = 0;
    @(negedge clk);
    checkEntry("R7 abort ignores boundary", 8'h0C, 3'd2, 1'b0, 1'b1);
    instrBoundary = 1;
    waitNeg(3);

    // R8 fiq mask passes through for a software interrupt
    maskFiqIn = 1;
    swInt = 1; @(negedge clk); swInt = 0;
    @(negedge clk);
    checkEntry("R8 swi keeps fiq mask", 8'h08, 3'd1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 mask passthrough after", 32'(maskIrqOut), 32'd0);
    maskFiqIn = 0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule